// File: doc/BRIEF.md
# Indexed Comparator Scan Sequencer

The block schedules a bank of comparator measurements over a table of index entries. Each entry selects one of a few channel configurations and carries an interrupt enable. In interval mode a current-entry pointer walks a programmable window of the table. Every entry occupies exactly one period of an internal timer, and after the last entry of the window the pointer returns to its first entry. In hardware-trigger mode the sequencer stays idle. The analog parts are not modelled: the comparator appears as a single digital result input, and the channel selection appears as outputs.

Inside each period the timer reaches a programmed compare count. At that cycle the registered comparator result is sampled and credited to the entry that owns the period, together with that entry's index. This holds even when the sample lands on the last cycle before the pointer moves on. Credited results set one bit per entry in a status register that software clears by writing 1, and the interrupt output is the OR of all status bits. A register write can soft-reset the whole block, and an init-done flag rises after a fixed count of cycles.

Top module: `cmp_scan_seq`

## Requirements
- R1: MODE (address 1) bit 0 selects the mode (0 = hardware trigger, 1 = interval) and bit 1 is the run bit. With bit 0 at 0 the pointer never moves, no status bit is set, and busy_o stays 0.
- R2: WINDOW (address 2) holds the window start in bits [4:0], the window end in bits [12:8] and the current pointer in bits [20:16], which reads back the live pointer. A write is ignored while busy_o is 1, and it is also ignored unless start <= current <= end.
- R3: While busy, the pointer advances by one at the end of each period. When it leaves the window end it wraps to the window start.
- R4: TIMER (address 3) holds the compare value in bits [15:0] and the terminal value in bits [31:16]. A period lasts terminal+1 cycles. A write whose terminal value is not greater than its compare value is ignored.
- R5: Clearing the run bit freezes the pointer. Setting it again resumes from the pointer value, with the timer restarting at count 0.
- R6: Entry i sits at address 32+i, with the channel select in bits [1:0] and the interrupt enable in bit 2. csel_o shows the channel select of the current entry.
- R7: The comparator input is registered once. On the cycle where the count equals the compare value, a registered result of 1 for an entry with its enable set sets that entry's status bit two cycles later. This holds when compare = terminal-1, and the following entry is never credited.
- R8: STATUS (address 4) holds one bit per entry. Writing 1 clears a bit, and writing 0 leaves it unchanged. irq_o is the OR of all status bits.
- R9: After reset, and after a write of 1 to bit 0 of CTRL (address 0), every register reads 0 except the timer (compare 0, terminal 1). The init count also restarts.
- R10: INIT (address 5) bit 0 rises INIT_THRD cycles after reset. Stepping does not start before it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| we_i | input | 1 | register write strobe |
| addr_i | input | PTR_W+1 | register address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i (combinational) |
| cmp_i | input | 1 | comparator result |
| irq_o | output | 1 | OR of status bits |
| entry_o | output | PTR_W | current entry index |
| csel_o | output | CSEL_W | channel select of current entry |
| sample_o | output | 1 | compare-cycle sample strobe |
| busy_o | output | 1 | stepping active |

## Verification
The bench builds the block with the full 32-entry table, so windows that end at entry 31 and wrap can be exercised. INIT_THRD is set to 8, which makes both sides of the init gate observable within a few register writes. Random windows, timer values, enable masks and period counts are checked against a pointer and status model. A directed case places a single comparator pulse so that it is sampled one cycle before the period boundary, to check that the result is credited to the entry that owned the period.

// File: rtl/cmp_scan_pkg.sv
package cmp_scan_pkg;
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_WIN  = 3'd2;
  localparam logic [2:0] REG_TMR  = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;
  localparam logic [2:0] REG_INIT = 3'd5;

  localparam int WIN_END_LSB = 8;
  localparam int WIN_CUR_LSB = 16;
  localparam int TMR_TERM_LSB = 16;

  typedef enum logic {
    MODE_HW       = 1'b0,
    MODE_INTERVAL = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/cmp_scan_timer.sv
module cmp_scan_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] cmp_val_i,
  input  logic [TMR_W-1:0] term_val_i,
  output logic             sample_o,
  output logic             end_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !run_i)     cnt_q <= '0;
    else if (cnt_q == term_val_i) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign sample_o = run_i && (cnt_q == cmp_val_i);
  assign end_o    = run_i && (cnt_q == term_val_i);
endmodule

// File: rtl/cmp_scan_window.sv
module cmp_scan_window #(
  parameter int PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic             lock_i,
  input  logic [PTR_W-1:0] wstart_i,
  input  logic [PTR_W-1:0] wend_i,
  input  logic [PTR_W-1:0] wcur_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] end_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic accept;
  assign accept = wr_i && !lock_i && (wstart_i <= wcur_i) && (wcur_i <= wend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      end_o   <= '0;
      ptr_o   <= '0;
    end else if (clr_i) begin
      start_o <= '0;
      end_o   <= '0;
      ptr_o   <= '0;
    end else if (accept) begin
      start_o <= wstart_i;
      end_o   <= wend_i;
      ptr_o   <= wcur_i;
    end else if (step_i) begin
      ptr_o <= (ptr_o == end_o) ? start_o : ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_scan_status.sv
module cmp_scan_status #(
  parameter int N_ENTRY = 32,
  parameter int PTR_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               hit_i,
  input  logic [PTR_W-1:0]   idx_i,
  input  logic [N_ENTRY-1:0] w1c_i,
  output logic [N_ENTRY-1:0] status_o
);
  // index captured with the hit so a following pointer step cannot retarget it
  logic             hit_q;
  logic [PTR_W-1:0] idx_q;
  logic [N_ENTRY-1:0] set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else if (clr_i) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_i;
      idx_q <= idx_i;
    end
  end

  always_comb begin
    set_vec = '0;
    if (hit_q) set_vec[idx_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_o <= '0;
    else if (clr_i) status_o <= '0;
    else            status_o <= (status_o & ~w1c_i) | set_vec;
  end
endmodule

// File: rtl/cmp_scan_seq.sv
module cmp_scan_seq
  import cmp_scan_pkg::*;
#(
  parameter int N_ENTRY   = 32,
  parameter int N_CFG     = 4,
  parameter int TMR_W     = 16,
  parameter int INIT_THRD = 64,
  localparam int PTR_W    = $clog2(N_ENTRY),
  localparam int CSEL_W   = $clog2(N_CFG),
  localparam int ADDR_W   = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              cmp_i,
  output logic              irq_o,
  output logic [PTR_W-1:0]  entry_o,
  output logic [CSEL_W-1:0] csel_o,
  output logic              sample_o,
  output logic              busy_o
);
  localparam int INIT_W = $clog2(INIT_THRD + 1);

  logic ent_sel;
  logic reg_wr;
  assign ent_sel = addr_i[ADDR_W-1];
  assign reg_wr  = we_i && !ent_sel;

  logic soft_clr, win_wr, tmr_wr, mode_wr, stat_wr;
  assign soft_clr = reg_wr && (addr_i[2:0] == REG_CTRL) && wdata_i[0];
  assign win_wr   = reg_wr && (addr_i[2:0] == REG_WIN);
  assign tmr_wr   = reg_wr && (addr_i[2:0] == REG_TMR);
  assign mode_wr  = reg_wr && (addr_i[2:0] == REG_MODE);
  assign stat_wr  = reg_wr && (addr_i[2:0] == REG_STAT);

  // init count
  logic [INIT_W-1:0] init_cnt_q;
  logic init_done;
  assign init_done = (init_cnt_q == INIT_W'(INIT_THRD));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         init_cnt_q <= '0;
    else if (soft_clr)   init_cnt_q <= '0;
    else if (!init_done) init_cnt_q <= init_cnt_q + 1'b1;
  end

  // mode and timer settings
  scan_mode_e       mode_q;
  logic             run_q;
  logic [TMR_W-1:0] cmp_val_q, term_val_q;
  logic [TMR_W-1:0] cmp_wd, term_wd;
  assign cmp_wd  = wdata_i[TMR_W-1:0];
  assign term_wd = wdata_i[TMR_TERM_LSB +: TMR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_HW;
      run_q      <= 1'b0;
      cmp_val_q  <= '0;
      term_val_q <= TMR_W'(1);
    end else if (soft_clr) begin
      mode_q     <= MODE_HW;
      run_q      <= 1'b0;
      cmp_val_q  <= '0;
      term_val_q <= TMR_W'(1);
    end else begin
      if (mode_wr) begin
        mode_q <= scan_mode_e'(wdata_i[0]);
        run_q  <= wdata_i[1];
      end
      if (tmr_wr && (term_wd > cmp_wd)) begin
        cmp_val_q  <= cmp_wd;
        term_val_q <= term_wd;
      end
    end
  end

  logic running;
  assign running = (mode_q == MODE_INTERVAL) && run_q && init_done;

  // entry table
  logic [CSEL_W-1:0] ent_csel_q [N_ENTRY];
  logic [N_ENTRY-1:0] ent_ie_q;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_csel_q[g] <= '0;
        ent_ie_q[g]   <= 1'b0;
      end else if (soft_clr) begin
        ent_csel_q[g] <= '0;
        ent_ie_q[g]   <= 1'b0;
      end else if (we_i && ent_sel && (addr_i[PTR_W-1:0] == PTR_W'(g))) begin
        ent_csel_q[g] <= wdata_i[CSEL_W-1:0];
        ent_ie_q[g]   <= wdata_i[CSEL_W];
      end
    end
  end

  // comparator input register
  logic cmp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= 1'b0;
    else if (soft_clr) cmp_q <= 1'b0;
    else               cmp_q <= cmp_i;
  end

  logic sample, step;
  cmp_scan_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_clr),
    .run_i      (running),
    .cmp_val_i  (cmp_val_q),
    .term_val_i (term_val_q),
    .sample_o   (sample),
    .end_o      (step)
  );

  logic [PTR_W-1:0] win_start, win_end, ptr;
  cmp_scan_window #(.PTR_W(PTR_W)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_clr),
    .wr_i     (win_wr),
    .lock_i   (running),
    .wstart_i (wdata_i[PTR_W-1:0]),
    .wend_i   (wdata_i[WIN_END_LSB +: PTR_W]),
    .wcur_i   (wdata_i[WIN_CUR_LSB +: PTR_W]),
    .step_i   (step),
    .start_o  (win_start),
    .end_o    (win_end),
    .ptr_o    (ptr)
  );

  logic hit;
  logic [N_ENTRY-1:0] w1c, status;
  assign hit = sample && cmp_q && ent_ie_q[ptr];
  assign w1c = stat_wr ? wdata_i[N_ENTRY-1:0] : '0;

  cmp_scan_status #(.N_ENTRY(N_ENTRY), .PTR_W(PTR_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_clr),
    .hit_i    (hit),
    .idx_i    (ptr),
    .w1c_i    (w1c),
    .status_o (status)
  );

  always_comb begin
    rdata_o = '0;
    if (ent_sel) begin
      rdata_o[CSEL_W-1:0] = ent_csel_q[addr_i[PTR_W-1:0]];
      rdata_o[CSEL_W]     = ent_ie_q[addr_i[PTR_W-1:0]];
    end else begin
      case (addr_i[2:0])
        REG_MODE: rdata_o[1:0] = {run_q, mode_q};
        REG_WIN: begin
          rdata_o[PTR_W-1:0]             = win_start;
          rdata_o[WIN_END_LSB +: PTR_W]  = win_end;
          rdata_o[WIN_CUR_LSB +: PTR_W]  = ptr;
        end
        REG_TMR: begin
          rdata_o[TMR_W-1:0]              = cmp_val_q;
          rdata_o[TMR_TERM_LSB +: TMR_W]  = term_val_q;
        end
        REG_STAT: rdata_o[N_ENTRY-1:0] = status;
        REG_INIT: rdata_o[0] = init_done;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o    = |status;
  assign entry_o  = ptr;
  assign csel_o   = ent_csel_q[ptr];
  assign sample_o = sample;
  assign busy_o   = running;
endmodule

// File: rtl/cmp_scan_seq_chk.sv
module cmp_scan_seq_chk #(
  parameter int N_ENTRY = 32,
  parameter int PTR_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               running_i,
  input logic               step_i,
  input logic               win_wr_i,
  input logic [PTR_W-1:0]   ptr_i,
  input logic [PTR_W-1:0]   start_i,
  input logic [PTR_W-1:0]   end_i,
  input logic [N_ENTRY-1:0] status_i,
  input logic               init_done_i
);
  // R2
  win_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i <= ptr_i) && (ptr_i <= end_i));

  // R5
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(running_i) && !$past(win_wr_i) && !$past(clr_i)) |-> $stable(ptr_i));

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ptr_i != $past(ptr_i)) && !$past(win_wr_i) && !$past(clr_i)) |-> $past(step_i));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(step_i) && ($past(ptr_i) == $past(end_i)) && !$past(clr_i)) |-> (ptr_i == $past(start_i)));

  // R7
  one_new_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_i & ~$past(status_i)) <= 1);

  // R10
  init_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_done_i) |-> $past(clr_i));
endmodule

bind cmp_scan_seq cmp_scan_seq_chk #(.N_ENTRY(N_ENTRY), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (soft_clr),
  .running_i   (running),
  .step_i      (step),
  .win_wr_i    (win_wr),
  .ptr_i       (ptr),
  .start_i     (win_start),
  .end_i       (win_end),
  .status_i    (status),
  .init_done_i (init_done)
);

// File: tb/cmp_scan_seq_test.sv
module cmp_scan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic we_i;
  logic [5:0] addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic cmp_i;
  logic irq_o;
  logic [4:0] entry_o;
  logic [1:0] csel_o;
  logic sample_o;
  logic busy_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmp_scan_seq #(.N_ENTRY(NE), .N_CFG(4), .TMR_W(16), .INIT_THRD(8)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmp_i(cmp_i), .irq_o(irq_o),
    .entry_o(entry_o), .csel_o(csel_o), .sample_o(sample_o), .busy_o(busy_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [1:0] b_csel [NE];
  logic       b_ie   [NE];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  function automatic logic [31:0] win_word(input int s, input int e, input int c);
    return (32'(c) << 16) | (32'(e) << 8) | 32'(s);
  endfunction

  function automatic int nxt(input int p, input int s, input int e);
    return (p == e) ? s : p + 1;
  endfunction

  task automatic wr_ent(input int i, input logic [1:0] cs, input logic ie);
    b_csel[i] = cs; b_ie[i] = ie;
    wr(6'(32 + i), {29'd0, ie, cs});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int exp_p;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; cmp_i = 1'b0;
    for (int i = 0; i < NE; i++) begin b_csel[i] = 2'd0; b_ie[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    rd(6'd5, d); chk("R10 init low after reset", d, 32'd0);
    rd(6'd4, d); chk("R9 status reset", d, 32'd0);
    rd(6'd2, d); chk("R9 window reset", d, 32'd0);
    rd(6'd3, d); chk("R9 timer reset", d, 32'h0001_0000);
    chk("R8 irq reset", {31'd0, irq_o}, 32'd0);

    // R10: stepping blocked until init done
    wr(6'd2, win_word(2, 4, 2));
    wr(6'd3, 32'h0002_0001);
    wr(6'd1, 32'd3);
    repeat (3) @(negedge clk_i);
    chk("R10 no stepping before init", {27'd0, entry_o}, 32'd2);
    chk("R10 busy low before init", {31'd0, busy_o}, 32'd0);
    repeat (20) @(negedge clk_i);
    rd(6'd5, d); chk("R10 init done", d, 32'd1);
    wr(6'd1, 32'd1);

    // R3/R4: wrap at top of table, period terminal+1 = 4
    wr(6'd2, win_word(29, 31, 30));
    wr(6'd3, 32'h0003_0001);
    wr(6'd1, 32'd3);
    repeat (3) @(negedge clk_i);
    chk("R4 entry held until terminal", {27'd0, entry_o}, 32'd30);
    @(negedge clk_i);
    chk("R3 advance", {27'd0, entry_o}, 32'd31);
    repeat (4) @(negedge clk_i);
    chk("R3 wrap to start", {27'd0, entry_o}, 32'd29);
    repeat (4) @(negedge clk_i);
    chk("R3 after wrap", {27'd0, entry_o}, 32'd30);

    // R2: window write ignored while running
    wr(6'd2, win_word(0, 7, 0));
    rd(6'd2, d); chk("R2 write locked while busy", {d[12:8], 3'd0, d[4:0]}, {5'd31, 3'd0, 5'd29});

    // R5: freeze and resume
    wr(6'd1, 32'd1);
    exp_p = entry_o;
    repeat (10) @(negedge clk_i);
    chk("R5 frozen", {27'd0, entry_o}, 32'(exp_p));
    wr(6'd1, 32'd3);
    repeat (3) @(negedge clk_i);
    chk("R5 resume held first period", {27'd0, entry_o}, 32'(exp_p));
    @(negedge clk_i);
    chk("R5 resume advances", {27'd0, entry_o}, 32'(nxt(exp_p, 29, 31)));
    wr(6'd1, 32'd1);

    // R2 invalid window ignored, R4 invalid timer ignored
    rd(6'd2, d); exp_p = int'(d);
    wr(6'd2, win_word(3, 5, 7));
    rd(6'd2, d); chk("R2 invalid window ignored", d, 32'(exp_p));
    wr(6'd3, 32'h0009_0009);
    rd(6'd3, d); chk("R4 invalid timer ignored", d, 32'h0003_0001);

    // R1: hardware-trigger mode stays idle
    for (int i = 0; i < NE; i++) wr_ent(i, 2'(i), 1'b1);
    wr(6'd4, 32'hffff_ffff);
    cmp_i = 1'b1;
    wr(6'd2, win_word(0, 3, 0));
    wr(6'd1, 32'd2);
    repeat (30) @(negedge clk_i);
    chk("R1 pointer idle in hw mode", {27'd0, entry_o}, 32'd0);
    rd(6'd4, d); chk("R1 no status in hw mode", d, 32'd0);
    chk("R1 busy low in hw mode", {31'd0, busy_o}, 32'd0);

    // R6: channel select of current entry
    wr_ent(5, 2'd3, 1'b1);
    wr(6'd2, win_word(5, 6, 5));
    chk("R6 csel of current entry", {30'd0, csel_o}, 32'd3);
    rd(6'd37, d); chk("R6 entry readback", d, 32'd7);

    // R7: result sampled one cycle before boundary is credited to the old entry
    wr(6'd1, 32'd1);
    cmp_i = 1'b0;
    wr(6'd2, win_word(10, 12, 10));
    wr(6'd3, 32'h0004_0003);
    repeat (3) @(negedge clk_i);
    wr(6'd1, 32'd3);
    repeat (2) @(negedge clk_i);
    cmp_i = 1'b1;
    @(negedge clk_i);
    cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7 pointer moved on", {27'd0, entry_o}, 32'd11);
    rd(6'd4, d); chk("R7 status on owning entry", d, 32'h0000_0400);
    chk("R8 irq set", {31'd0, irq_o}, 32'd1);
    wr(6'd1, 32'd1);

    // R8: write 1 to clear, zeros leave bits
    wr(6'd4, 32'h0000_0008);
    rd(6'd4, d); chk("R8 unrelated clear keeps bit", d, 32'h0000_0400);

    // R9: soft reset
    wr(6'd0, 32'd1);
    rd(6'd4, d); chk("R9 soft reset status", d, 32'd0);
    rd(6'd2, d); chk("R9 soft reset window", d, 32'd0);
    rd(6'd1, d); chk("R9 soft reset mode", d, 32'd0);
    rd(6'd37, d); chk("R9 soft reset entry", d, 32'd0);
    rd(6'd5, d); chk("R10 init restarts", d, 32'd0);
    chk("R8 irq clear after soft reset", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < NE; i++) begin b_csel[i] = 2'd0; b_ie[i] = 1'b0; end
    repeat (20) @(negedge clk_i);

    // directed W1C of a set bit
    wr_ent(0, 2'd1, 1'b1);
    cmp_i = 1'b1;
    wr(6'd2, win_word(0, 0, 0));
    wr(6'd3, 32'h0003_0001);
    wr(6'd1, 32'd3);
    repeat (8) @(negedge clk_i);
    wr(6'd1, 32'd1);
    rd(6'd4, d); chk("R7 single-entry window sets bit", d, 32'd1);
    wr(6'd4, 32'd1);
    rd(6'd4, d); chk("R8 write one clears", d, 32'd0);
    chk("R8 irq falls", {31'd0, irq_o}, 32'd0);

    // random scans
    for (int it = 0; it < 20; it++) begin
      int s, e, c, cv, tv, n, p;
      logic [31:0] exp_st;
      s  = $urandom % NE;
      e  = s + ($urandom % (NE - s));
      c  = s + ($urandom % (e - s + 1));
      cv = 1 + ($urandom % 4);
      tv = cv + 1 + ($urandom % 4);
      n  = 1 + ($urandom % 6);
      for (int i = 0; i < NE; i++) wr_ent(i, 2'($urandom), 1'($urandom));
      wr(6'd1, 32'd1);
      wr(6'd4, 32'hffff_ffff);
      wr(6'd2, win_word(s, e, c));
      wr(6'd3, (32'(tv) << 16) | 32'(cv));
      wr(6'd1, 32'd3);
      repeat (n * (tv + 1)) @(negedge clk_i);
      p = c; exp_st = '0;
      for (int k = 0; k < n; k++) begin
        if (b_ie[p]) exp_st[p] = 1'b1;
        p = nxt(p, s, e);
      end
      chk("R3 random pointer", {27'd0, entry_o}, 32'(p));
      chk("R6 random csel", {30'd0, csel_o}, {30'd0, b_csel[p]});
      wr(6'd1, 32'd1);
      rd(6'd4, d); chk("R7 random status", d, exp_st);
      chk("R8 random irq", {31'd0, irq_o}, {31'd0, |exp_st});
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule